// File: doc/BRIEF.md
# Return Address Stack with Repair

This block keeps a small circular stack of predicted return addresses for an instruction fetch unit. When fetch sees a call it asserts the push strobe with the call's own PC. The block stores the address of the next sequential instruction, which is that PC plus a fixed instruction size. When fetch sees a return, it reads the current top value as the predicted target and then asserts the pop strobe. The block never decides on its own when to push or pop, and it plays no part in predicting branch direction.

Speculation can be undone. Before it pops for a return, fetch keeps a copy of the top index and the top value. If that return is squashed later, the restore port forces the top pointer back to the kept index and writes the kept value into that slot. This reverses the pop exactly, even if a younger push has since overwritten the slot. A squashed call is undone with one plain pop. The stack is circular: a push when all slots are in use overwrites the oldest entry, and a pop from the bottom slot wraps to the highest index without any error.

Each cycle one operation is chosen from four: OP_IDLE (no change), OP_PUSH (advance the pointer and write the link address), OP_POP (step the pointer back) and OP_RESTORE (load the pointer and rewrite that slot). Only the operation in force in a cycle moves the pointer or writes an entry.

Top module: `return_addr_stack`

## Requirements
- R1: After reset the top index is 0 and every entry holds 0, so the top value is 0.
- R2: A push changes the top index to (index+1) mod DEPTH at the next clock edge. From then on, the top value reads push_pc + INSTR_BYTES.
- R3: A pop changes the top index to (index−1) mod DEPTH, so index 0 goes to DEPTH−1. It modifies no entry.
- R4: A restore sets the top index to restore_idx and writes restore_tgt into that slot. The top value then reads restore_tgt.
- R5: When strobes coincide, restore beats push and push beats pop. The losing strobe has no effect.
- R6: A push made while all DEPTH slots hold live entries overwrites the oldest slot. After DEPTH+1 pushes, the top value is the newest link address and the index has wrapped.
- R7: Suppose the top index and value are captured before a pop, and then further pushes follow. A restore with the captured pair returns top_idx and top_addr to the captured pair.
- R8: A push followed at once by a single pop leaves top_idx and top_addr as they were before the push.
- R9: top_idx and top_addr are combinational views of the current state. They change in the cycle after the clock edge that performed the operation, with no additional delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_en | input | 1 | Call seen: push the link address |
| push_pc | input | ADDR_W | PC of the call instruction |
| pop_en | input | 1 | Return seen: drop the top entry |
| restore_en | input | 1 | Repair: load pointer and rewrite slot |
| restore_idx | input | PTR_W | Saved top index to reinstate |
| restore_tgt | input | ADDR_W | Saved top value to write back |
| top_addr | output | ADDR_W | Entry at the top index (predicted return target) |
| top_idx | output | PTR_W | Current top pointer |

## Verification
The bench aims at the wrap points. One case pops from index 0, where a design that failed to wrap would read a slot outside the stack. Another pushes DEPTH+1 times, where a saturating design would stall the pointer and report a stale top value. It undoes a pop after a younger push has overwritten the same slot. A design that restored only the pointer would then return the younger call's link address in place of the saved target. It also drives push with pop, and restore with push, in the same cycle. A wrong priority shows up as a pointer moved in the wrong direction, or a slot holding the link address where the restored target should be.

// File: rtl/ras_pkg.sv
package ras_pkg;

    // One operation applied per clock edge
    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_PUSH    = 2'd1,
        OP_POP     = 2'd2,
        OP_RESTORE = 2'd3
    } ras_op_e;

endpackage

// File: rtl/ras_op_decode.sv
module ras_op_decode
    import ras_pkg::*;
(
    input  logic    push_en,
    input  logic    pop_en,
    input  logic    restore_en,
    output ras_op_e op
);

    // Fixed priority: repair first, then call, then return
    always_comb begin
        if (restore_en)
            op = OP_RESTORE;
        else if (push_en)
            op = OP_PUSH;
        else if (pop_en)
            op = OP_POP;
        else
            op = OP_IDLE;
    end

    // R5
    always_comb begin
        restore_wins_chk: assert (!(restore_en && op != OP_RESTORE));
        // R5
        push_over_pop_chk: assert (!(push_en && !restore_en && op != OP_PUSH));
    end

endmodule

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
    import ras_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ras_op_e          op,
    input  logic [PTR_W-1:0] restore_idx,
    output logic [PTR_W-1:0] ptr,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] ptr_inc;
    logic [PTR_W-1:0] ptr_dec;
    logic [PTR_W-1:0] ptr_nxt;

    assign ptr_inc = (ptr == LAST) ? '0 : ptr + PTR_W'(1);
    assign ptr_dec = (ptr == '0) ? LAST : ptr - PTR_W'(1);

    // Next-state and write-port decisions
    always_comb begin
        ptr_nxt = ptr;
        wr_en   = 1'b0;
        wr_idx  = ptr;
        unique case (op)
            OP_IDLE: begin
                ptr_nxt = ptr;
            end
            OP_PUSH: begin
                ptr_nxt = ptr_inc;
                wr_en   = 1'b1;
                wr_idx  = ptr_inc;
            end
            OP_POP: begin
                ptr_nxt = ptr_dec;
            end
            OP_RESTORE: begin
                ptr_nxt = restore_idx;
                wr_en   = 1'b1;
                wr_idx  = restore_idx;
            end
            default: begin
                ptr_nxt = ptr;
            end
        endcase
    end

    // Pointer register
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else
            ptr <= ptr_nxt;
    end

    // R1
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST);

    // R2
    push_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PUSH && ptr == LAST) |=> ptr == '0);

    // R3
    pop_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_POP && ptr == '0) |=> ptr == LAST);

    // R4
    restore_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_RESTORE |=> ptr == $past(restore_idx));

    // R4
    restore_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_RESTORE |-> restore_idx <= LAST);

endmodule

// File: rtl/ras_entry_store.sv
module ras_entry_store #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_data
);

    logic [ADDR_W-1:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[g] <= '0;
            else if (wr_en && wr_idx == PTR_W'(g))
                slot[g] <= wr_data;
        end
    end

    // Read mux over all slots
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == PTR_W'(i))
                rd_data = slot[i];
        end
    end

    // R6
    wr_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_idx <= PTR_W'(DEPTH - 1));

endmodule

// File: rtl/return_addr_stack.sv
module return_addr_stack
    import ras_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int ADDR_W      = 32,
    parameter int INSTR_BYTES = 4,
    parameter int PTR_W       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [ADDR_W-1:0] push_pc,
    input  logic              pop_en,
    input  logic              restore_en,
    input  logic [PTR_W-1:0]  restore_idx,
    input  logic [ADDR_W-1:0] restore_tgt,
    output logic [ADDR_W-1:0] top_addr,
    output logic [PTR_W-1:0]  top_idx
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

    ras_op_e           op;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_idx;
    logic [ADDR_W-1:0] wr_data;
    logic [ADDR_W-1:0] link_addr;

    ras_op_decode u_decode (
        .push_en    (push_en),
        .pop_en     (pop_en),
        .restore_en (restore_en),
        .op         (op)
    );

    ras_ptr_ctrl #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W)
    ) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .restore_idx (restore_idx),
        .ptr         (top_idx),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx)
    );

    // Link address of a call: next sequential instruction
    assign link_addr = push_pc + STEP;
    assign wr_data   = (op == OP_RESTORE) ? restore_tgt : link_addr;

    ras_entry_store #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .PTR_W  (PTR_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (top_idx),
        .rd_data (top_addr)
    );

    // R2
    push_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && !restore_en) |=> top_addr == $past(push_pc) + STEP);

    // R4
    restore_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_en |=> top_addr == $past(restore_tgt));

    // R8
    call_undo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && !restore_en) ##1 (pop_en && !push_en && !restore_en)
        |=> top_idx == $past(top_idx, 2));

endmodule

// File: tb/return_addr_stack_bench.sv
module return_addr_stack_bench;

    localparam int DEPTH   = 8;
    localparam int ADDR_W  = 32;
    localparam int INSTR   = 4;
    localparam int PTR_W   = $clog2(DEPTH);
    localparam int PERIOD  = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push_en = 1'b0;
    logic [ADDR_W-1:0] push_pc = '0;
    logic              pop_en = 1'b0;
    logic              restore_en = 1'b0;
    logic [PTR_W-1:0]  restore_idx = '0;
    logic [ADDR_W-1:0] restore_tgt = '0;
    logic [ADDR_W-1:0] top_addr;
    logic [PTR_W-1:0]  top_idx;

    int checks = 0;
    int fails  = 0;

    // Behavioural reference: array plus integer pointer
    logic [ADDR_W-1:0] ref_mem [DEPTH];
    int ref_ptr = 0;

    always #(PERIOD/2) clk = ~clk;

    return_addr_stack #(
        .DEPTH       (DEPTH),
        .ADDR_W      (ADDR_W),
        .INSTR_BYTES (INSTR)
    ) u_return_addr_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_en     (push_en),
        .push_pc     (push_pc),
        .pop_en      (pop_en),
        .restore_en  (restore_en),
        .restore_idx (restore_idx),
        .restore_tgt (restore_tgt),
        .top_addr    (top_addr),
        .top_idx     (top_idx)
    );

    task automatic check_val(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check_val({tag, " top_idx"}, int'(top_idx), ref_ptr);
        check_val({tag, " top_addr"}, int'(top_addr), int'(ref_mem[ref_ptr]));
    endtask

    // Drive one cycle at a negedge, update model, compare at next negedge
    task automatic step(input logic ps, input logic [ADDR_W-1:0] pc,
                        input logic pp, input logic rs, input int ri,
                        input logic [ADDR_W-1:0] rt, input string tag);
        push_en     = ps;
        push_pc     = pc;
        pop_en      = pp;
        restore_en  = rs;
        restore_idx = PTR_W'(ri);
        restore_tgt = rt;
        if (rs) begin
            ref_ptr = ri;
            ref_mem[ri] = rt;
        end else if (ps) begin
            ref_ptr = (ref_ptr + 1) % DEPTH;
            ref_mem[ref_ptr] = pc + INSTR;
        end else if (pp) begin
            ref_ptr = (ref_ptr + DEPTH - 1) % DEPTH;
        end
        @(negedge clk);
        push_en    = 1'b0;
        pop_en     = 1'b0;
        restore_en = 1'b0;
        compare(tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        int cap_i;
        logic [ADDR_W-1:0] cap_a;
        logic [31:0] lfsr;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        compare("R1 reset");
        step(0, 0, 0, 0, 0, 0, "R1 idle");

        // R2 pushes
        step(1, 32'h1000, 0, 0, 0, 0, "R2 push");
        step(1, 32'h2000, 0, 0, 0, 0, "R2 push");
        step(1, 32'h3000, 0, 0, 0, 0, "R2 push");
        // R3 pops
        step(0, 0, 1, 0, 0, 0, "R3 pop");
        step(0, 0, 1, 0, 0, 0, "R3 pop");
        step(0, 0, 1, 0, 0, 0, "R3 pop to 0");
        step(0, 0, 1, 0, 0, 0, "R3 pop wrap");
        check_val("R3 wrap index", int'(top_idx), DEPTH - 1);
        step(0, 0, 1, 0, 0, 0, "R3 pop after wrap");

        // R6 overflow
        for (int i = 0; i < DEPTH + 2; i++)
            step(1, 32'h4000 + 32'(i * 16), 0, 0, 0, 0, "R6 fill");
        check_val("R6 newest link", int'(top_addr), 32'h4000 + (DEPTH + 1) * 16 + INSTR);

        // R7 repair of a squashed return
        step(1, 32'h5000, 0, 0, 0, 0, "R7 push");
        cap_i = int'(top_idx);
        cap_a = top_addr;
        step(0, 0, 1, 0, 0, 0, "R7 pop");
        step(1, 32'h6000, 0, 0, 0, 0, "R7 younger push");
        step(1, 32'h7000, 0, 0, 0, 0, "R7 younger push");
        step(0, 0, 0, 1, cap_i, cap_a, "R7 restore");
        check_val("R7 index back", int'(top_idx), cap_i);
        check_val("R7 value back", int'(top_addr), int'(cap_a));

        // R4 restore arbitrary slot
        step(0, 0, 0, 1, 2, 32'hABCD0, "R4 restore");
        check_val("R4 value", int'(top_addr), 32'hABCD0);

        // R8 squashed call
        cap_i = int'(top_idx);
        cap_a = top_addr;
        step(1, 32'h8000, 0, 0, 0, 0, "R8 push");
        step(0, 0, 1, 0, 0, 0, "R8 pop");
        check_val("R8 index", int'(top_idx), cap_i);
        check_val("R8 value", int'(top_addr), int'(cap_a));

        // R5 priority
        step(1, 32'h9000, 1, 0, 0, 0, "R5 push beats pop");
        step(1, 32'hA000, 1, 1, 5, 32'h1234, "R5 restore beats all");
        step(0, 0, 1, 1, 0, 32'h5678, "R5 restore beats pop");

        // R9 streams of mixed operations, compared every clock
        lfsr = 32'hACE1_1357;
        for (int n = 0; n < 400; n++) begin
            logic ps, pp, rs;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            ps = lfsr[0] & ~lfsr[5];
            pp = lfsr[1];
            rs = (lfsr[4:2] == 3'b000);
            step(ps, {lfsr[23:2], 2'b00}, pp, rs, int'(lfsr[10:8]) % DEPTH,
                 {lfsr[31:12], 12'h0}, "R9 stream");
        end
        finish_run();
    end

endmodule